// File: doc/BRIEF.md
# Delayed-Start Receive Sequencer

This block runs one receive operation from the moment it is started until the incoming signal goes away. A start command loads a programmable wait count, which then counts down once per bit-clock enable. During the last three counts an output tells the analog front end to get ready. When the count reaches zero the block waits for a signal that is both valid and stronger than a programmable 4-bit threshold.

Once a qualifying signal is present, the block watches the decoded bit stream for a start-of-frame pattern. After the pattern it packs bits into bytes and writes each finished byte through a FIFO write port. When the signal is lost, the block writes out any partial byte along with a count of its valid bits. It then raises a sticky receive-done flag, which stays set until the host clears it.

A 3-bit modem-state output reports the current phase. Line decoding and the analog circuitry lie outside the block: it takes in a decoded bit, a signal-valid flag and a digitized signal level.

Top module: `rx_delay_seq`

## Requirements
- R1: While reset is asserted and just after it is released, modem_state is 0 (idle), rx_prep is 0, fifo_wr is 0 and done_irq is 0.
- R2: A start in idle loads wait_cfg, or 3 if wait_cfg is below 3. The count drops by one on each bit_en. modem_state is 1 (wait) while the remaining count is above 3. A start with wait_cfg below 3 goes straight to modem_state 2.
- R3: modem_state is 2 (prepare) and rx_prep is 1 while the remaining count is 3, 2 or 1, which lasts exactly three bit_en pulses. rx_prep is 0 in every other state.
- R4: The bit_en that brings the count to 0 moves modem_state to 3 (awaiting signal).
- R5: From state 3, the block moves to state 4 (awaiting start of frame) only on a bit_en where sig_valid is 1 and sig_level is strictly greater than min_level. If the level only equals the threshold, or sig_valid is 0, the state stays at 3.
- R6: In state 4, each bit_en with sig_valid high shifts rx_bit into a history. When the last four bits, oldest first, form 1101, modem_state becomes 5 (receiving). No bit received before the pattern ends is written to the FIFO.
- R7: In state 5, bits fill a byte starting at the least significant bit. The cycle after the bit_en that brings in the eighth bit, fifo_wr is high for one cycle, with fifo_data holding the byte and fifo_bits holding 8.
- R8: A bit_en with sig_valid low in state 4 or 5 moves modem_state to 6 (done) and sets done_irq. If 1 to 7 bits of a byte were collected, they are written once with fifo_bits equal to that count and the unused upper bits set to 0. If no bits are pending, nothing is written.
- R9: done_irq stays at 1 until a cycle where done_clr is high. If a new set and a clear fall in the same cycle, the set wins.
- R10: start is ignored in states 1 through 5 and accepted in states 0 and 6.
- R11: In states 1 through 5, the state and the count do not change in any cycle where bit_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a receive operation (pulse) |
| wait_cfg | input | WAIT_W | Programmed wait count |
| min_level | input | LVL_W | Signal-strength threshold |
| bit_en | input | 1 | Bit-clock enable, one pulse per bit period |
| sig_valid | input | 1 | Signal detected by the front end |
| sig_level | input | LVL_W | Digitized signal strength |
| rx_bit | input | 1 | Decoded data bit |
| done_clr | input | 1 | Host clear of done_irq |
| modem_state | output | 3 | Phase code 0 to 6 |
| rx_prep | output | 1 | Analog receiver preparation request |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | BYTE_W | Byte being written |
| fifo_bits | output | clog2(BYTE_W+1) | Number of valid bits in fifo_data |
| done_irq | output | 1 | Sticky receive-done flag |

## Verification
The assertions check on every cycle that:
- the count stays above 3 in the wait phase and between 1 and 3 in the prepare phase;
- the loaded count is never below 3;
- FIFO writes come only from the receiving phase and always carry a bit count between 1 and 8;
- done_irq holds until it is cleared;
- the phase never moves in a counting or receiving state without a bit enable.

Other behaviour can only be shown by the bench's scenarios, where a behavioural model is compared against the outputs every cycle. This covers the strict greater-than level gate, recognition of the frame pattern after junk bits, the least-significant-bit-first byte order, and the flush of a partial byte compared with a loss exactly on a byte boundary. It also covers a start that arrives in the middle of an operation and is ignored.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [2:0] {
    MS_IDLE = 3'd0,
    MS_WAIT = 3'd1,
    MS_PREP = 3'd2,
    MS_ARM  = 3'd3,
    MS_SOF  = 3'd4,
    MS_RECV = 3'd5,
    MS_DONE = 3'd6
  } modem_st_e;
endpackage

// File: rtl/rxs_countdown.sv
module rxs_countdown #(
  parameter int W   = 8,
  parameter int MIN = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] cfg,
  output logic [W-1:0] cnt,
  output logic         long_wait
);
  localparam logic [W-1:0] MINV = W'(MIN);

  logic [W-1:0] ld_val;
  logic [W-1:0] cnt_q, cnt_d;

  assign ld_val    = (cfg < MINV) ? MINV : cfg;
  assign long_wait = ld_val > MINV;
  assign cnt       = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = ld_val;
    end else if (dec && cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q >= MINV); // R2
endmodule

// File: rtl/rxs_sof_hunt.sv
module rxs_sof_hunt #(
  parameter int               SOF_W   = 4,
  parameter logic [SOF_W-1:0] SOF_PAT = 4'b1101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift,
  input  logic bit_in,
  output logic hit
);
  localparam int HW = SOF_W - 1;

  logic [HW-1:0] hist_q, hist_d;

  assign hit = shift && ({hist_q, bit_in} == SOF_PAT);

  always_comb begin
    hist_d = hist_q;
    if (clr) begin
      hist_d = '0;
    end else if (shift) begin
      hist_d = {hist_q[HW-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/rxs_deser.sv
module rxs_deser #(
  parameter int BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          shift,
  input  logic                          flush,
  input  logic                          bit_in,
  output logic                          wr,
  output logic [BYTE_W-1:0]             data,
  output logic [$clog2(BYTE_W+1)-1:0]   nbits
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam int NB_W  = $clog2(BYTE_W+1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTE_W-1);

  logic [BYTE_W-1:0] acc_q, acc_d, nxt;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wr_q, wr_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [NB_W-1:0]   nb_q, nb_d;

  assign wr    = wr_q;
  assign data  = data_q;
  assign nbits = nb_q;

  always_comb begin
    acc_d  = acc_q;
    idx_d  = idx_q;
    wr_d   = 1'b0;
    data_d = data_q;
    nb_d   = nb_q;
    nxt    = acc_q;
    nxt[idx_q] = bit_in;
    if (clr) begin
      acc_d = '0;
      idx_d = '0;
    end else if (shift) begin
      if (idx_q == LAST) begin
        wr_d   = 1'b1;
        data_d = nxt;
        nb_d   = NB_W'(BYTE_W);
        acc_d  = '0;
        idx_d  = '0;
      end else begin
        acc_d = nxt;
        idx_d = idx_q + IDX_W'(1);
      end
    end else if (flush && idx_q != '0) begin
      wr_d   = 1'b1;
      data_d = acc_q;
      nb_d   = NB_W'(idx_q);
      acc_d  = '0;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      idx_q  <= '0;
      wr_q   <= 1'b0;
      data_q <= '0;
      nb_q   <= '0;
    end else begin
      acc_q  <= acc_d;
      idx_q  <= idx_d;
      wr_q   <= wr_d;
      data_q <= data_d;
      nb_q   <= nb_d;
    end
  end

  AST_NBITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (nb_q != '0 && nb_q <= NB_W'(BYTE_W))); // R8
endmodule

// File: rtl/rx_delay_seq.sv
module rx_delay_seq
  import rxs_pkg::*;
#(
  parameter int               WAIT_W  = 8,
  parameter int               LVL_W   = 4,
  parameter int               BYTE_W  = 8,
  parameter int               PREP_N  = 3,
  parameter int               SOF_W   = 4,
  parameter logic [SOF_W-1:0] SOF_PAT = 4'b1101
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [WAIT_W-1:0]                  wait_cfg,
  input  logic [LVL_W-1:0]                   min_level,
  input  logic                               bit_en,
  input  logic                               sig_valid,
  input  logic [LVL_W-1:0]                   sig_level,
  input  logic                               rx_bit,
  input  logic                               done_clr,
  output logic [2:0]                         modem_state,
  output logic                               rx_prep,
  output logic                               fifo_wr,
  output logic [BYTE_W-1:0]                  fifo_data,
  output logic [$clog2(BYTE_W+1)-1:0]        fifo_bits,
  output logic                               done_irq
);
  modem_st_e         st_q, st_d;
  logic              done_q, done_d;
  logic [WAIT_W-1:0] cnt;
  logic              long_wait, load, dec, qualify;
  logic              sof_hit, sh_en, ds_shift, ds_flush;

  assign load     = start && (st_q == MS_IDLE || st_q == MS_DONE);
  assign dec      = bit_en && (st_q == MS_WAIT || st_q == MS_PREP);
  assign qualify  = sig_valid && (sig_level > min_level);
  assign sh_en    = bit_en && sig_valid && (st_q == MS_SOF);
  assign ds_shift = bit_en && sig_valid && (st_q == MS_RECV);
  assign ds_flush = bit_en && !sig_valid && (st_q == MS_RECV);

  rxs_countdown #(.W(WAIT_W), .MIN(PREP_N)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .dec(dec),
    .cfg(wait_cfg), .cnt(cnt), .long_wait(long_wait)
  );

  rxs_sof_hunt #(.SOF_W(SOF_W), .SOF_PAT(SOF_PAT)) u_sof (
    .clk(clk), .rst_n(rst_n), .clr(load), .shift(sh_en),
    .bit_in(rx_bit), .hit(sof_hit)
  );

  rxs_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .clr(load), .shift(ds_shift),
    .flush(ds_flush), .bit_in(rx_bit), .wr(fifo_wr),
    .data(fifo_data), .nbits(fifo_bits)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MS_IDLE, MS_DONE: if (load) st_d = long_wait ? MS_WAIT : MS_PREP;
      MS_WAIT: if (bit_en && cnt == WAIT_W'(PREP_N + 1)) st_d = MS_PREP;
      MS_PREP: if (bit_en && cnt == WAIT_W'(1)) st_d = MS_ARM;
      MS_ARM:  if (bit_en && qualify) st_d = MS_SOF;
      MS_SOF: begin
        if (bit_en && !sig_valid) st_d = MS_DONE;
        else if (sof_hit)         st_d = MS_RECV;
      end
      MS_RECV: if (bit_en && !sig_valid) st_d = MS_DONE;
      default: st_d = MS_IDLE;
    endcase
  end

  always_comb begin
    done_d = done_q;
    if (st_d == MS_DONE && st_q != MS_DONE) begin
      done_d = 1'b1;
    end else if (done_clr) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MS_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign modem_state = st_q;
  assign rx_prep     = (st_q == MS_PREP);
  assign done_irq    = done_q;

  AST_WAIT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_WAIT) |-> (cnt > WAIT_W'(PREP_N))); // R2
  AST_PREP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_PREP) |-> (cnt != '0 && cnt <= WAIT_W'(PREP_N))); // R3
  AST_WR_IN_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> ($past(st_q) == MS_RECV)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_clr) |=> done_q); // R9
  AST_NO_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && st_q inside {MS_WAIT, MS_PREP, MS_ARM, MS_SOF, MS_RECV})
      |=> ($stable(st_q) && $stable(cnt))); // R11
endmodule

// File: tb/rx_delay_seq_bench.sv
module rx_delay_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, bit_en, sig_valid, rx_bit, done_clr;
  logic [7:0] wait_cfg;
  logic [3:0] min_level, sig_level;
  logic [2:0] modem_state;
  logic       rx_prep, fifo_wr, done_irq;
  logic [7:0] fifo_data;
  logic [3:0] fifo_bits;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  int m_st, m_cnt, m_hist, m_acc, m_idx, m_data, m_nb;
  bit m_wr, m_done;
  int got[$];

  always #5 clk = ~clk;

  rx_delay_seq u_rx_delay_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_cfg(wait_cfg),
    .min_level(min_level), .bit_en(bit_en), .sig_valid(sig_valid),
    .sig_level(sig_level), .rx_bit(rx_bit), .done_clr(done_clr),
    .modem_state(modem_state), .rx_prep(rx_prep), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .fifo_bits(fifo_bits), .done_irq(done_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_hist = 0; m_acc = 0; m_idx = 0;
      m_wr = 0; m_done = 0; m_data = 0; m_nb = 0;
    end else begin
      m_wr = 0;
      if (done_clr) m_done = 0;
      case (m_st)
        0, 6: if (start) begin
          m_cnt = (wait_cfg < 3) ? 3 : int'(wait_cfg);
          m_st = (m_cnt > 3) ? 1 : 2;
          m_hist = 0; m_acc = 0; m_idx = 0;
        end
        1, 2: if (bit_en) begin
          m_cnt--;
          if (m_cnt == 0) m_st = 3;
          else if (m_cnt <= 3) m_st = 2;
        end
        3: if (bit_en && sig_valid && sig_level > min_level) m_st = 4;
        4: if (bit_en) begin
          if (!sig_valid) begin m_st = 6; m_done = 1; end
          else begin
            m_hist = ((m_hist << 1) | int'(rx_bit)) & 15;
            if (m_hist == 13) begin m_st = 5; m_idx = 0; m_acc = 0; end
          end
        end
        5: if (bit_en) begin
          if (!sig_valid) begin
            if (m_idx > 0) begin m_wr = 1; m_data = m_acc; m_nb = m_idx; end
            m_st = 6; m_done = 1; m_idx = 0; m_acc = 0;
          end else begin
            m_acc = m_acc | (int'(rx_bit) << m_idx);
            m_idx++;
            if (m_idx == 8) begin
              m_wr = 1; m_data = m_acc; m_nb = 8; m_acc = 0; m_idx = 0;
            end
          end
        end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(modem_state == m_st, "R2/R4/R5/R6/R10 modem_state", modem_state, m_st);
      chk(rx_prep == (m_st == 2), "R3 rx_prep", rx_prep, m_st == 2);
      chk(fifo_wr == m_wr, "R7 fifo_wr", fifo_wr, m_wr);
      if (m_wr) begin
        chk(fifo_data == m_data, "R7 fifo_data", fifo_data, m_data);
        chk(fifo_bits == m_nb, "R8 fifo_bits", fifo_bits, m_nb);
      end
      chk(done_irq == m_done, "R9 done_irq", done_irq, m_done);
      if (fifo_wr) got.push_back({fifo_bits, fifo_data});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      finish_run();
    end
  end

  task automatic tick();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  task automatic send(input bit b);
    sig_valid = 1'b1; rx_bit = b;
    tick();
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send(v[i]);
  endtask

  task automatic lose();
    sig_valid = 1'b0;
    tick();
  endtask

  task automatic do_start(input logic [7:0] w);
    wait_cfg = w;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic clear_done();
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 0; bit_en = 0; sig_valid = 0; rx_bit = 0; done_clr = 0;
    wait_cfg = 0; min_level = 4'd6; sig_level = 0;
    repeat (3) @(negedge clk);
    chk(modem_state == 0 && !rx_prep && !fifo_wr && !done_irq, "R1 reset state",
        modem_state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(modem_state == 0 && !done_irq, "R1 after release", modem_state, 0);

    // long wait: 6 -> 4 in wait, 3..1 prepare, 0 armed
    do_start(8'd6);
    chk(modem_state == 1, "R2 wait after start", modem_state, 1);
    tick(); tick();
    chk(modem_state == 1 && !rx_prep, "R2 still waiting at 4", modem_state, 1);
    tick();
    chk(modem_state == 2 && rx_prep, "R3 prepare at 3", modem_state, 2);
    tick(); tick();
    chk(modem_state == 2 && rx_prep, "R3 prepare at 1", modem_state, 2);
    repeat (5) @(negedge clk);
    chk(modem_state == 2, "R11 no advance without bit_en", modem_state, 2);
    tick();
    chk(modem_state == 3 && !rx_prep, "R4 armed at zero", modem_state, 3);

    // level gate: equal is not enough
    sig_level = 4'd6;
    send(1'b0);
    chk(modem_state == 3, "R5 level equal to threshold", modem_state, 3);
    sig_level = 4'd7;
    send(1'b0);
    chk(modem_state == 4, "R5 level above threshold", modem_state, 4);

    // junk then frame pattern 1101
    send(0); send(1); send(0);
    chk(modem_state == 4, "R6 still hunting after junk", modem_state, 4);
    send(1); send(1); send(0); send(1);
    chk(modem_state == 5, "R6 pattern found", modem_state, 5);
    chk(got.size() == 0, "R6 no write before pattern", got.size(), 0);

    send_byte(8'hA5);
    send_byte(8'h3C);
    send(1); send(0); send(1);
    lose();
    @(negedge clk);
    chk(modem_state == 6 && done_irq, "R8 done on loss", modem_state, 6);
    chk(got.size() == 3, "R7 write count", got.size(), 3);
    if (got.size() == 3) begin
      chk(got[0] == 12'h8A5, "R7 first byte LSB first", got[0], 12'h8A5);
      chk(got[1] == 12'h83C, "R7 second byte", got[1], 12'h83C);
      chk(got[2] == 12'h305, "R8 partial byte with count", got[2], 12'h305);
    end
    repeat (4) @(negedge clk);
    chk(done_irq == 1'b1, "R9 done sticky", done_irq, 1);
    clear_done();
    chk(done_irq == 1'b0, "R9 done cleared", done_irq, 0);

    // clamp and ignored restart
    got.delete();
    do_start(8'd1);
    chk(modem_state == 2, "R2 clamp to three", modem_state, 2);
    do_start(8'd200);
    chk(modem_state == 2, "R10 start ignored while busy", modem_state, 2);
    tick(); tick(); tick();
    chk(modem_state == 3, "R10 count not reloaded", modem_state, 3);
    sig_level = 4'd9;
    send(0);
    chk(modem_state == 4, "R5 armed to hunting", modem_state, 4);
    send(1); send(1);
    lose();
    @(negedge clk);
    chk(modem_state == 6 && done_irq, "R8 loss while hunting", modem_state, 6);
    chk(got.size() == 0, "R8 no write without bits", got.size(), 0);

    // restart from done without clearing, loss on byte boundary
    do_start(8'd3);
    chk(modem_state == 2, "R10 start accepted in done", modem_state, 2);
    chk(done_irq == 1'b1, "R9 start leaves flag", done_irq, 1);
    clear_done();
    tick(); tick(); tick();
    sig_valid = 1'b0; tick();
    chk(modem_state == 3, "R5 no signal keeps armed", modem_state, 3);
    send(0);
    send(1); send(1); send(0); send(1);
    send_byte(8'hFF);
    lose();
    @(negedge clk);
    chk(got.size() == 1, "R8 boundary loss writes once", got.size(), 1);
    if (got.size() == 1) chk(got[0] == 12'h8FF, "R7 full byte", got[0], 12'h8FF);
    chk(done_irq == 1'b1, "R8 done set again", done_irq, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule